// File: doc/BRIEF.md
# Non-Retriggerable Gated One-Shot Pulser

This block is a clocked monostable. It watches two trigger inputs of opposite sense and an active-low clear. When a qualified trigger edge is seen, it drives a single pulse whose length in clock cycles comes from a width input. It also drives the inverse of that pulse. Each trigger input acts as an enable for the other. Once a pulse is running, it cannot be restarted or stretched. Clear forces the output low at any time.

A rising edge on clear can also start a pulse. For that, the trigger inputs must first be taken through their inhibiting levels and back. This arming sequence keeps a plain release of clear from firing again and again.

All three control inputs enter through a synchronizer of `SYNC_STAGES` flops. Edges are found by comparing each synchronized sample with the sample one cycle older. A designer who needs two channels places two instances side by side.

Top module: `oneshot_pulser`

## Requirements
- R1: While reset is active and right after reset, `pulse` is 0 and `pulse_n` is 1. The clear-trigger arm flag starts set.
- R2: While `clear_n` is low, `pulse` stays 0 whatever `trig_n` and `trig_p` do.
- R3: A falling edge on `trig_n` while `trig_p` is 1 and `clear_n` is 1 starts a pulse. `pulse` first reads 1 after the third rising clock edge following the input change (SYNC_STAGES+1 edges).
- R4: A rising edge on `trig_p` while `trig_n` is 0 and `clear_n` is 1 starts a pulse, with the same three-edge latency.
- R5: `trig_n` at 1 or `trig_p` at 0 inhibits triggering. A falling `trig_n` with `trig_p` low, a rising `trig_p` with `trig_n` high, and any edge that leaves the other input at its inhibiting level all produce no pulse.
- R6: A pulse lasts exactly `width` clock cycles, with a `width` of 0 giving 1 cycle. `width` is taken on the edge that starts the pulse, and later changes do not alter a running pulse.
- R7: While `pulse` is 1, edges on `trig_n` and `trig_p` are ignored. The pulse is not lengthened and no second pulse follows it.
- R8: Taking `clear_n` low during a pulse ends it. `pulse` reads 0 after the third rising edge following the change.
- R9: A rising edge on `clear_n` starts a pulse when `trig_n` is 0, `trig_p` is 1 and the arm flag is set. Any trigger clears the flag. The flag is set again only while `trig_n` is 1 or `trig_p` is 0.
- R10: `pulse_n` is always the inverse of `pulse`.
- R11: The synchronizers reset to `trig_n`=1, `trig_p`=0, `clear_n`=1. Inputs held at other levels through reset are seen as edges after release. For example, `trig_n` held low with `trig_p` high gives a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_n | input | 1 | Trigger input that fires on its falling edge; a high level inhibits |
| trig_p | input | 1 | Trigger input that fires on its rising edge; a low level inhibits |
| clear_n | input | 1 | Active-low overriding clear; its rising edge may trigger when armed |
| width | input | CNT_W | Pulse length in clock cycles, 0 treated as 1 |
| pulse | output | 1 | Pulse output, high while the one-shot runs |
| pulse_n | output | 1 | Inverse of `pulse` |

## Verification
Every input change shows up at `pulse` after the third rising edge that follows it. This holds whether the change starts a pulse or, through clear, ends one. The bench drives inputs on falling clock edges and samples on falling edges. It expects `pulse` low at the first two samples after a trigger and high from the third sample on. For an expected pulse it counts consecutive high samples and compares the count with `width`. It then watches twenty more samples to catch a stretched or queued pulse. For a clear that cuts a pulse short, it expects high at the two samples after the change and low at the third.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Reset levels of the synchronized inputs (the non-triggering levels)
    localparam logic TRIG_N_IDLE = 1'b1;
    localparam logic TRIG_P_IDLE = 1'b0;
    localparam logic CLEAR_IDLE  = 1'b1;

    typedef struct packed {
        logic neg_prev;
        logic pos_prev;
        logic clr_prev;
        logic armed;
    } trig_state_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig
    import oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic neg_s,
    input  logic pos_s,
    input  logic clr_s,
    input  logic busy,
    output logic start
);

    trig_state_t st_d, st_q;
    logic neg_fall, pos_rise, clr_rise;
    logic fire_neg, fire_pos, fire_clr;

    always_comb begin
        neg_fall = st_q.neg_prev & ~neg_s;
        pos_rise = ~st_q.pos_prev & pos_s;
        clr_rise = ~st_q.clr_prev & clr_s;

        fire_neg = neg_fall & pos_s  & clr_s & ~busy;
        fire_pos = pos_rise & ~neg_s & clr_s & ~busy;
        fire_clr = clr_rise & ~neg_s & pos_s & st_q.armed & ~busy;
        start    = fire_neg | fire_pos | fire_clr;

        st_d          = st_q;
        st_d.neg_prev = neg_s;
        st_d.pos_prev = pos_s;
        st_d.clr_prev = clr_s;
        if (neg_s || !pos_s) st_d.armed = 1'b1;
        if (start)           st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{neg_prev: TRIG_N_IDLE, pos_prev: TRIG_P_IDLE,
                      clr_prev: CLEAR_IDLE,  armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    start_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (clr_s && !neg_s && pos_s));

    // R9
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !st_q.armed);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr_ok,
    input  logic [CNT_W-1:0] width,
    output logic             busy
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (!clr_ok) begin
            tm_d.busy = 1'b0;
            tm_d.cnt  = '0;
        end else if (start) begin
            tm_d.busy = 1'b1;
            tm_d.cnt  = (width == '0) ? '0 : width - CNT_W'(1);
        end else if (tm_q.busy) begin
            if (tm_q.cnt == '0) tm_d.busy = 1'b0;
            else                tm_d.cnt  = tm_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign busy = tm_q.busy;

    // R7
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.busy |-> !start);

    // R6
    pulse_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clr_ok) |=> busy);

endmodule

// File: rtl/oneshot_pulser.sv
module oneshot_pulser
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_n,
    input  logic             trig_p,
    input  logic             clear_n,
    input  logic [CNT_W-1:0] width,
    output logic             pulse,
    output logic             pulse_n
);

    localparam int          N_IN     = 3;
    localparam logic [2:0]  SYNC_RST = {CLEAR_IDLE, TRIG_P_IDLE, TRIG_N_IDLE};

    logic [N_IN-1:0] raw_in, sync_out;
    logic neg_s, pos_s, clr_s, start, busy;

    assign raw_in = {clear_n, trig_p, trig_n};

    oneshot_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_out)
    );

    assign neg_s = sync_out[0];
    assign pos_s = sync_out[1];
    assign clr_s = sync_out[2];

    oneshot_trig i_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .neg_s(neg_s),
        .pos_s(pos_s),
        .clr_s(clr_s),
        .busy (busy),
        .start(start)
    );

    oneshot_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .clr_ok(clr_s),
        .width (width),
        .busy  (busy)
    );

    assign pulse   = busy;
    assign pulse_n = ~busy;

    // R2
    clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> !pulse);

endmodule

// File: tb/test_oneshot_pulser.sv
module test_oneshot_pulser;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_n = 1'b1;
    logic trig_p = 1'b0;
    logic clear_n = 1'b1;
    logic [15:0] width = 16'd1;
    logic pulse, pulse_n;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    oneshot_pulser i_oneshot_pulser (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .trig_p(trig_p),
        .clear_n(clear_n), .width(width), .pulse(pulse), .pulse_n(pulse_n)
    );

    typedef struct packed {
        logic        a0, b0, a1, b1;
        logic [15:0] w;
        logic [15:0] len;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'd5,  16'd5,  4'd3},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd7,  16'd7,  4'd4},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'd5,  16'd0,  4'd5},
        '{1'b1, 1'b0, 1'b1, 1'b1, 16'd5,  16'd0,  4'd5},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'd0,  16'd1,  4'd6},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd1,  16'd1,  4'd6},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'd20, 16'd20, 4'd6},
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd4,  16'd0,  4'd5},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd4,  16'd0,  4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd40, 16'd40, 4'd6}
    };

    function automatic string tag_s(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after the stimulus at a falling edge.
    task automatic run_pulse(output int len, output bit early,
                             output bit extra, output bit inv_bad);
        len = 0; early = 0; extra = 0; inv_bad = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (pulse) early = 1;
            if (pulse_n !== ~pulse) inv_bad = 1;
        end
        @(negedge clk);
        while (pulse === 1'b1 && len < 400) begin
            len++;
            if (pulse_n !== 1'b0) inv_bad = 1;
            @(negedge clk);
        end
        for (int i = 0; i < 20; i++) begin
            if (pulse !== 1'b0) extra = 1;
            if (pulse_n !== ~pulse) inv_bad = 1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int len;
        bit early, extra, inv_bad;

        // R1: reset state
        idle(3);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R1", "pulse during reset", pulse, 0);
        rst_n = 1'b1;
        idle(4);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R1", "pulse after reset", pulse, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            trig_n = 1'b1; trig_p = 1'b0;
            idle(4);
            width = VECS[v].w;
            trig_n = VECS[v].a0; trig_p = VECS[v].b0;
            idle(6);
            check(pulse == 1'b0, "R5", "preset levels gave pulse", pulse, 0);
            trig_n = VECS[v].a1; trig_p = VECS[v].b1;
            run_pulse(len, early, extra, inv_bad);
            check(len == int'(VECS[v].len) && !early && !extra, tag_s(VECS[v].tag),
                  $sformatf("vector %0d pulse length", v), len, VECS[v].len);
            check(!inv_bad, "R10", "pulse_n not inverse", inv_bad, 0);
        end

        // R2 and R9: clear low holds output, then clear rise fires (armed from reset path)
        trig_n = 1'b1; trig_p = 1'b0; idle(4);
        clear_n = 1'b0; idle(4);
        trig_n = 1'b0; trig_p = 1'b1; idle(6);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R2", "pulse while clear low", pulse, 0);
        width = 16'd4;
        clear_n = 1'b1;
        run_pulse(len, early, extra, inv_bad);
        check(len == 4 && !early && !extra, "R9", "clear-rise trigger length", len, 4);

        // R9: second clear rise without re-arming gives nothing
        clear_n = 1'b0; idle(5);
        clear_n = 1'b1;
        run_pulse(len, early, extra, inv_bad);
        check(len == 0 && !extra, "R9", "unarmed clear rise", len, 0);

        // R9: re-arm by taking trig_n high, then clear rise fires again
        clear_n = 1'b0; idle(3);
        trig_n = 1'b1; idle(5);
        trig_n = 1'b0; idle(5);
        clear_n = 1'b1;
        run_pulse(len, early, extra, inv_bad);
        check(len == 4 && !early, "R9", "re-armed clear rise", len, 4);

        // R7 and R6: edges and width change during a pulse are ignored
        trig_n = 1'b1; trig_p = 1'b0; idle(4);
        trig_p = 1'b1; idle(5);
        width = 16'd10;
        trig_n = 1'b0;
        fork
            run_pulse(len, early, extra, inv_bad);
            begin
                idle(4); trig_n = 1'b1;
                idle(1); width = 16'd3;
                idle(1); trig_n = 1'b0;
            end
        join
        check(len == 10 && !early, "R6", "width change mid-pulse", len, 10);
        check(!extra, "R7", "retrigger queued a pulse", extra, 0);

        // R8: clear cuts a running pulse
        trig_n = 1'b1; trig_p = 1'b0; idle(4);
        trig_p = 1'b1; idle(5);
        width = 16'd30;
        trig_n = 1'b0;
        idle(7);
        check(pulse == 1'b1, "R3", "pulse before clear", pulse, 1);
        clear_n = 1'b0;
        idle(1);
        check(pulse == 1'b1, "R8", "pulse 1 sample after clear", pulse, 1);
        idle(1);
        check(pulse == 1'b1, "R8", "pulse 2 samples after clear", pulse, 1);
        idle(1);
        check(pulse == 1'b0 && pulse_n == 1'b1, "R8", "pulse 3 samples after clear", pulse, 0);
        idle(5);
        check(pulse == 1'b0, "R2", "pulse stays low under clear", pulse, 0);
        // R9: no arming since the trig_n trigger, so clear rise does nothing
        clear_n = 1'b1;
        run_pulse(len, early, extra, inv_bad);
        check(len == 0 && !extra, "R9", "clear rise after edge trigger", len, 0);

        // R11: levels held through reset are seen as edges
        rst_n = 1'b0;
        trig_n = 1'b0; trig_p = 1'b1; clear_n = 1'b1; width = 16'd2;
        idle(3);
        check(pulse == 1'b0, "R1", "pulse in second reset", pulse, 0);
        rst_n = 1'b1;
        run_pulse(len, early, extra, inv_bad);
        check(len == 2 && !early && !extra, "R11", "pulse from reset levels", len, 2);

        summary();
        $finish;
    end

endmodule